// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block holds the software-visible registers of a two-channel scatter-gather DMA engine. Channel 0 moves data from memory to a stream (transmit), and channel 1 moves data from a stream to memory (receive). Each channel has a control word, a status word, a current-descriptor pointer, a tail-descriptor pointer and some plain storage words. All of them sit on a simple byte-offset bus with separate write and read strobes. Reads return their data one cycle after the strobe.

The descriptor engine is not part of this block. It sees each channel's run, halted and idle state and both descriptor pointers. Software kicks a channel by writing its tail pointer. That write produces a one-cycle tail-update pulse, and on the transmit channel it also produces a start pulse. The engine reports back with per-channel event strobes: halt, idle, slave error, decode error, error interrupt and clear-run. The completion count and the delay count are kept outside the block. They arrive as 8-bit input fields and appear in the upper half of the status word on a read.

Each channel's halted and idle bits form a four-state machine of type `chan_state_e`. The states are ST_ACTIVE (neither bit set), ST_HALTED, ST_IDLE and ST_HALT_IDLE. Bus actions move the machine through the named transitions below. The soft-reset action (ACT_SRST) goes to ST_HALTED. The start action (ACT_RUN) goes to ST_ACTIVE. A status write (ACT_STATW) loads both bits from the written data. The tail kick (ACT_TAIL) clears idle: ST_IDLE goes to ST_ACTIVE and ST_HALT_IDLE goes to ST_HALTED. ACT_NONE holds the state. Engine halt and idle events are then ORed on top of the result.

Top module: `dma_chan_regs`

## Requirements
- R1: The channel is bit 0 of (offset / 48). The register index is (offset mod 48) / 4. Offset 0x68 therefore reaches channel 0, index 2.
- R2: After hardware reset, control reads 0x00010002 and the low half of status reads 0x0001. Both pointers are 0, and every channel is halted, not idle and not running.
- R3: Control bit 1 (tail mode) always reads as 1, whatever value was written.
- R4: A control write with bit 2 set, or any control write while bit 2 is already set, reinitialises the channel. Control becomes 0x00010002 with bit 2 held, the status low half becomes 0x0001, and run is not honoured.
- R5: A control read (index 0) returns bit 2 as 0 and clears it. After that read, a run write takes effect.
- R6: A control write with bit 0 set while the channel is not resetting clears both halted (status bit 0) and idle (status bit 1).
- R7: A write to index 4 stores the tail pointer and clears idle. One cycle later it pulses that channel's tail-update output, and on channel 0 only it also pulses tx_start.
- R8: A status write (index 1) loads status bits 15:0, except that bits 14:12 become 0. Bits 1:0 set halted and idle.
- R9: Engine strobes set halted (bit 0), idle (bit 1), slave error (bit 5), decode error (bit 6) and error interrupt (bit 14). Clear-run clears control bit 0. Each effect is visible one cycle after the strobe.
- R10: An engine strobe takes priority over a same-cycle bus write to the same bit.
- R11: A status read returns the completion count input in bits 23:16 and the delay count input in bits 31:24, as sampled on the read cycle.
- R12: Index 2 (current descriptor) and the other unmapped indices are plain read/write storage.
- R13: Read data appears one cycle after the read strobe and holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| eng_set_halted | input | 2 | Per-channel engine halt event |
| eng_set_idle | input | 2 | Per-channel engine idle event |
| eng_set_slverr | input | 2 | Per-channel slave error event |
| eng_set_decerr | input | 2 | Per-channel decode error event |
| eng_set_errirq | input | 2 | Per-channel error interrupt event |
| eng_clear_run | input | 2 | Per-channel run-bit clear |
| irq_count | input | 16 | Completion count, 8 bits per channel |
| irq_delay | input | 16 | Delay count, 8 bits per channel |
| tail_upd | output | 2 | Tail-pointer update pulse per channel |
| tx_start | output | 1 | Start pulse to the transmit engine |
| chan_run | output | 2 | Control run bit per channel |
| chan_halted | output | 2 | Halted status per channel |
| chan_idle | output | 2 | Idle status per channel |
| cur_desc_o | output | 64 | Current-descriptor pointers, 32 bits per channel |
| tail_desc_o | output | 64 | Tail-descriptor pointers, 32 bits per channel |

## Verification
On every cycle, the assertions check the following:
- engine halt and idle strobes are reflected one cycle later, and clear-run removes the run bit;
- a start write clears halted and idle unless an engine event collides with it;
- a soft-reset write leaves the channel halted and stopped;
- every tail or start pulse has a tail write one cycle earlier;
- read data changes only after a read strobe.

Only the bench's scenarios can show the following:
- the address aliasing;
- a soft reset that persists across further control writes and is released only by a control read;
- the interrupt-field masking on status writes;
- the count fields merged into status reads;
- that tx_start never fires for the receive channel.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int DATA_W   = 32;
    localparam int NREG     = 12;
    localparam int RIDX_W   = 4;

    localparam int RI_CTRL  = 0;
    localparam int RI_STAT  = 1;
    localparam int RI_CUR   = 2;
    localparam int RI_TAIL  = 4;

    localparam int CB_RUN   = 0;
    localparam int CB_TMODE = 1;
    localparam int CB_SRST  = 2;

    localparam int SB_SLV    = 5;
    localparam int SB_DEC    = 6;
    localparam int SB_IRQ_LO = 12;
    localparam int SB_IRQ_HI = 14;
    localparam int SB_ERRIRQ = 14;

    localparam logic [DATA_W-1:0] CTRL_INIT = 32'h0001_0002;

    // encoding is {idle, halted}
    typedef enum logic [1:0] {
        ST_ACTIVE    = 2'b00,
        ST_HALTED    = 2'b01,
        ST_IDLE      = 2'b10,
        ST_HALT_IDLE = 2'b11
    } chan_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_SRST,
        ACT_RUN,
        ACT_STATW,
        ACT_TAIL
    } bus_act_e;

    typedef struct packed {
        logic halt;
        logic idle;
        logic slverr;
        logic decerr;
        logic errirq;
        logic clr_run;
    } eng_ev_t;

endpackage

// File: rtl/dma_addr_dec.sv
module dma_addr_dec #(
    parameter int AW        = 8,
    parameter int WIN_BYTES = 48
) (
    input  logic [AW-1:0]                   addr,
    output logic                            chan_sel,
    output logic [dma_regs_pkg::RIDX_W-1:0] reg_idx
);
    localparam logic [AW-1:0] WIN = AW'(WIN_BYTES);

    // R1: window number modulo two picks the channel
    assign chan_sel = 1'(addr / WIN);
    assign reg_idx  = dma_regs_pkg::RIDX_W'((addr % WIN) >> 2);
endmodule

// File: rtl/dma_chan_core.sv
module dma_chan_core
    import dma_regs_pkg::*;
#(
    parameter bit IS_TX = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [RIDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0]  wdata,
    input  eng_ev_t            ev,
    input  logic [7:0]         cnt_fld,
    input  logic [7:0]         dly_fld,
    output logic [DATA_W-1:0]  rd_val,
    output logic               tail_pulse,
    output logic               start_pulse,
    output logic               run,
    output logic               halted,
    output logic               idle,
    output logic [DATA_W-1:0]  cur_desc,
    output logic [DATA_W-1:0]  tail_desc
);
    logic [DATA_W-1:0] ctrl_q, ctrl_d, ctrl_wv;
    logic [15:2]       flags_q, flags_d;
    logic [DATA_W-1:0] store_q [NREG];
    chan_state_e       state_q, state_d, state_bus;
    bus_act_e          act;
    logic              wr_ctrl, wr_stat, wr_tail, rd_ctrl, srst_req, run_req;
    logic              tail_pulse_q;

    assign wr_ctrl = wr_en && (reg_idx == RIDX_W'(RI_CTRL));
    assign wr_stat = wr_en && (reg_idx == RIDX_W'(RI_STAT));
    assign wr_tail = wr_en && (reg_idx == RIDX_W'(RI_TAIL));
    assign rd_ctrl = rd_en && (reg_idx == RIDX_W'(RI_CTRL));

    // R3/R4: tail mode forced, reset bit sticky across writes
    always_comb begin
        ctrl_wv           = wdata;
        ctrl_wv[CB_TMODE] = 1'b1;
        ctrl_wv[CB_SRST]  = wdata[CB_SRST] | ctrl_q[CB_SRST];
    end
    assign srst_req = ctrl_wv[CB_SRST];
    assign run_req  = wr_ctrl && !srst_req && wdata[CB_RUN];

    always_comb begin
        if (wr_ctrl && srst_req) act = ACT_SRST;
        else if (run_req)        act = ACT_RUN;
        else if (wr_stat)        act = ACT_STATW;
        else if (wr_tail)        act = ACT_TAIL;
        else                     act = ACT_NONE;
    end

    // control word next value
    always_comb begin
        ctrl_d = ctrl_q;
        if (rd_ctrl) ctrl_d[CB_SRST] = 1'b0;          // R5
        if (wr_ctrl) begin
            if (srst_req) begin
                ctrl_d          = CTRL_INIT;
                ctrl_d[CB_SRST] = 1'b1;
            end else begin
                ctrl_d = ctrl_wv;
            end
        end
        if (ev.clr_run) ctrl_d[CB_RUN] = 1'b0;        // R10
    end

    // status flags next value
    always_comb begin
        flags_d = flags_q;
        if (act == ACT_SRST) begin
            flags_d = '0;
        end else if (wr_stat) begin
            flags_d = wdata[15:2];
            flags_d[SB_IRQ_HI:SB_IRQ_LO] = '0;         // R8
        end
        if (ev.slverr) flags_d[SB_SLV]    = 1'b1;
        if (ev.decerr) flags_d[SB_DEC]    = 1'b1;
        if (ev.errirq) flags_d[SB_ERRIRQ] = 1'b1;
    end

    // halted/idle state machine: bus transitions, then engine overlay
    always_comb begin
        unique case (act)
            ACT_SRST:  state_bus = ST_HALTED;
            ACT_RUN:   state_bus = ST_ACTIVE;
            ACT_STATW: state_bus = chan_state_e'(wdata[1:0]);
            ACT_TAIL: begin
                unique case (state_q)
                    ST_IDLE:      state_bus = ST_ACTIVE;
                    ST_HALT_IDLE: state_bus = ST_HALTED;
                    ST_ACTIVE:    state_bus = ST_ACTIVE;
                    ST_HALTED:    state_bus = ST_HALTED;
                    default:      state_bus = state_q;
                endcase
            end
            default:   state_bus = state_q;
        endcase
        state_d = chan_state_e'(state_bus | {ev.idle, ev.halt});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALTED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_INIT;
            flags_q <= '0;
            for (int i = 0; i < NREG; i++) store_q[i] <= '0;
        end else begin
            ctrl_q  <= ctrl_d;
            flags_q <= flags_d;
            if (wr_en && !wr_ctrl && !wr_stat) store_q[reg_idx] <= wdata;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) tail_pulse_q <= 1'b0;
        else        tail_pulse_q <= wr_tail;
    end

    assign tail_pulse = tail_pulse_q;

    generate
        if (IS_TX) begin : g_tx
            assign start_pulse = tail_pulse_q;
        end else begin : g_rx
            assign start_pulse = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (reg_idx)
            RIDX_W'(RI_CTRL): begin
                rd_val          = ctrl_q;
                rd_val[CB_SRST] = 1'b0;
            end
            RIDX_W'(RI_STAT): rd_val = {dly_fld, cnt_fld, flags_q, state_q};
            default:          rd_val = store_q[reg_idx];
        endcase
    end

    assign run       = ctrl_q[CB_RUN];
    assign halted    = state_q[0];
    assign idle      = state_q[1];
    assign cur_desc  = store_q[RI_CUR];
    assign tail_desc = store_q[RI_TAIL];

    a_r9_eng_halt: assert property (@(posedge clk) disable iff (!rst_n)
        ev.halt |=> halted);
    a_r9_eng_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ev.idle |=> idle);
    a_r10_clr_run_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev.clr_run |=> !run);
    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[CB_RUN] && !wdata[CB_SRST] && !ctrl_q[CB_SRST]
         && !ev.halt && !ev.idle) |=> (!halted && !idle));
    a_r4_srst_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && (wdata[CB_SRST] || ctrl_q[CB_SRST])) |=> (halted && !run));
    a_r7_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_pulse || start_pulse) |-> $past(wr_en && reg_idx == RIDX_W'(RI_TAIL)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int AW        = 8,
    parameter int WIN_BYTES = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  eng_set_halted,
    input  logic [1:0]  eng_set_idle,
    input  logic [1:0]  eng_set_slverr,
    input  logic [1:0]  eng_set_decerr,
    input  logic [1:0]  eng_set_errirq,
    input  logic [1:0]  eng_clear_run,
    input  logic [15:0] irq_count,
    input  logic [15:0] irq_delay,
    output logic [1:0]  tail_upd,
    output logic        tx_start,
    output logic [1:0]  chan_run,
    output logic [1:0]  chan_halted,
    output logic [1:0]  chan_idle,
    output logic [63:0] cur_desc_o,
    output logic [63:0] tail_desc_o
);
    localparam int NCH = 2;

    logic              chan_sel;
    logic [RIDX_W-1:0] reg_idx;
    logic [DATA_W-1:0] rd_val [NCH];
    logic [NCH-1:0]    start_v;

    dma_addr_dec #(.AW(AW), .WIN_BYTES(WIN_BYTES)) u_dec (
        .addr     (bus_addr[AW-1:0]),
        .chan_sel (chan_sel),
        .reg_idx  (reg_idx)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            eng_ev_t ev;
            assign ev.halt    = eng_set_halted[ch];
            assign ev.idle    = eng_set_idle[ch];
            assign ev.slverr  = eng_set_slverr[ch];
            assign ev.decerr  = eng_set_decerr[ch];
            assign ev.errirq  = eng_set_errirq[ch];
            assign ev.clr_run = eng_clear_run[ch];

            dma_chan_core #(.IS_TX(ch == 0)) u_core (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_en       (bus_wr && (chan_sel == 1'(ch))),
                .rd_en       (bus_rd && (chan_sel == 1'(ch))),
                .reg_idx     (reg_idx),
                .wdata       (bus_wdata),
                .ev          (ev),
                .cnt_fld     (irq_count[ch*8 +: 8]),
                .dly_fld     (irq_delay[ch*8 +: 8]),
                .rd_val      (rd_val[ch]),
                .tail_pulse  (tail_upd[ch]),
                .start_pulse (start_v[ch]),
                .run         (chan_run[ch]),
                .halted      (chan_halted[ch]),
                .idle        (chan_idle[ch]),
                .cur_desc    (cur_desc_o[ch*32 +: 32]),
                .tail_desc   (tail_desc_o[ch*32 +: 32])
            );
        end
    endgenerate

    assign tx_start = start_v[0] | start_v[1];

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val[chan_sel];
    end

    a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    a_r7_no_rx_start: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> tail_upd[0]);
endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [1:0]  e_halt = 0, e_idle = 0, e_slv = 0, e_dec = 0, e_err = 0, e_clr = 0;
    logic [15:0] irq_count = 0, irq_delay = 0;
    logic [1:0]  tail_upd, chan_run, chan_halted, chan_idle;
    logic        tx_start;
    logic [63:0] cur_desc_o, tail_desc_o;

    always #2 clk = ~clk;  // 250 MHz

    dma_chan_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_set_halted(e_halt), .eng_set_idle(e_idle), .eng_set_slverr(e_slv),
        .eng_set_decerr(e_dec), .eng_set_errirq(e_err), .eng_clear_run(e_clr),
        .irq_count(irq_count), .irq_delay(irq_delay), .tail_upd(tail_upd),
        .tx_start(tx_start), .chan_run(chan_run), .chan_halted(chan_halted),
        .chan_idle(chan_idle), .cur_desc_o(cur_desc_o), .tail_desc_o(tail_desc_o)
    );

    int    checks = 0, fails = 0;
    bit    done = 0;
    string cur_req = "R2";

    // behavioural reference model
    logic [31:0] m_ctrl [2];
    logic [15:0] m_stat [2];
    logic [31:0] m_store [2][12];
    logic [31:0] m_rdata;
    logic [1:0]  m_tail;
    logic        m_start;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_ctrl[c] = 32'h0001_0002;
                m_stat[c] = 16'h0001;
                for (int i = 0; i < 12; i++) m_store[c][i] = 0;
            end
            m_rdata = 0; m_tail = 0; m_start = 0;
        end else begin
            int ch, ri;
            logic [31:0] v;
            ch = (int'(bus_addr) / 48) % 2;
            ri = (int'(bus_addr) % 48) / 4;
            m_tail = 0; m_start = 0;
            if (bus_rd) begin
                if (ri == 0) begin
                    m_rdata = m_ctrl[ch] & ~32'h4;
                    m_ctrl[ch] = m_ctrl[ch] & ~32'h4;
                end else if (ri == 1) begin
                    m_rdata = {irq_delay[ch*8 +: 8], irq_count[ch*8 +: 8], m_stat[ch]};
                end else begin
                    m_rdata = m_store[ch][ri];
                end
            end
            if (bus_wr) begin
                if (ri == 0) begin
                    v = bus_wdata | 32'h2 | (m_ctrl[ch] & 32'h4);
                    if (v[2]) begin
                        m_ctrl[ch] = 32'h0001_0006;
                        m_stat[ch] = 16'h0001;
                    end else begin
                        m_ctrl[ch] = v;
                        if (v[0]) m_stat[ch] = m_stat[ch] & ~16'h3;
                    end
                end else if (ri == 1) begin
                    m_stat[ch] = bus_wdata[15:0] & ~16'h7000;
                end else begin
                    m_store[ch][ri] = bus_wdata;
                    if (ri == 4) begin
                        m_stat[ch] = m_stat[ch] & ~16'h2;
                        m_tail[ch] = 1;
                        if (ch == 0) m_start = 1;
                    end
                end
            end
            for (int c = 0; c < 2; c++) begin
                if (e_halt[c]) m_stat[c][0]  = 1;
                if (e_idle[c]) m_stat[c][1]  = 1;
                if (e_slv[c])  m_stat[c][5]  = 1;
                if (e_dec[c])  m_stat[c][6]  = 1;
                if (e_err[c])  m_stat[c][14] = 1;
                if (e_clr[c])  m_ctrl[c][0]  = 0;
            end
        end
    end

    task automatic chk(string fld, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", cur_req, fld, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("rdata", 64'(bus_rdata), 64'(m_rdata));
            chk("tx_start", 64'(tx_start), 64'(m_start));
            chk("tail_upd", 64'(tail_upd), 64'(m_tail));
            for (int c = 0; c < 2; c++) begin
                chk("run",    64'(chan_run[c]),    64'(m_ctrl[c][0]));
                chk("halted", 64'(chan_halted[c]), 64'(m_stat[c][0]));
                chk("idle",   64'(chan_idle[c]),   64'(m_stat[c][1]));
                chk("cur",    64'(cur_desc_o[c*32 +: 32]),  64'(m_store[c][2]));
                chk("tail",   64'(tail_desc_o[c*32 +: 32]), 64'(m_store[c][4]));
            end
        end
    end

    task automatic idle_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd_expect(logic [7:0] a, logic [31:0] exp);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0;
        chk("readback", 64'(bus_rdata), 64'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle_cyc(2);

        cur_req = "R2";  rd_expect(8'h00, 32'h0001_0002);
        cur_req = "R2";  rd_expect(8'h04, 32'h0000_0001);
        cur_req = "R2";  rd_expect(8'h34, 32'h0000_0001);

        cur_req = "R12"; wr(8'h08, 32'h0000_1000); rd_expect(8'h08, 32'h0000_1000);
        cur_req = "R12"; wr(8'h2C, 32'hCAFE_0001); rd_expect(8'h2C, 32'hCAFE_0001);
        cur_req = "R1";  wr(8'h38, 32'h0000_2000); rd_expect(8'h38, 32'h0000_2000);
        cur_req = "R1";  rd_expect(8'h68, 32'h0000_1000);

        cur_req = "R3";  wr(8'h00, 32'h0000_0000); rd_expect(8'h00, 32'h0000_0002);
        cur_req = "R6";  wr(8'h00, 32'h0001_0001); rd_expect(8'h04, 32'h0000_0000);
        cur_req = "R6";  wr(8'h30, 32'h0000_0001); idle_cyc(1);

        cur_req = "R9";
        @(negedge clk); e_idle = 2'b01; @(negedge clk); e_idle = 0;
        rd_expect(8'h04, 32'h0000_0002);
        cur_req = "R7";  wr(8'h10, 32'h0000_3000); rd_expect(8'h10, 32'h0000_3000);
        cur_req = "R7";  wr(8'h40, 32'h0000_4000); idle_cyc(1);

        cur_req = "R8";  wr(8'h04, 32'h0000_7063);
        irq_count = 16'h5A12; irq_delay = 16'hA534;
        cur_req = "R11"; rd_expect(8'h04, 32'h3412_0063);
        cur_req = "R11"; rd_expect(8'h34, 32'hA55A_0000);

        cur_req = "R9";  wr(8'h04, 32'h0);
        @(negedge clk); e_slv = 2'b10; e_dec = 2'b10; e_err = 2'b10; e_halt = 2'b10; e_clr = 2'b10;
        @(negedge clk); e_slv = 0; e_dec = 0; e_err = 0; e_halt = 0; e_clr = 0;
        rd_expect(8'h34, 32'hA55A_4061);
        cur_req = "R9";  rd_expect(8'h30, 32'h0000_0002);

        cur_req = "R10";
        @(negedge clk); bus_wr = 1; bus_addr = 8'h04; bus_wdata = 0; e_halt = 2'b01;
        @(negedge clk); bus_wr = 0; e_halt = 0;
        rd_expect(8'h04, 32'h3412_0001);
        cur_req = "R10";
        @(negedge clk); bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'h1; e_clr = 2'b01; e_idle = 2'b01;
        @(negedge clk); bus_wr = 0; e_clr = 0; e_idle = 0;
        rd_expect(8'h04, 32'h3412_0002);

        cur_req = "R4";  wr(8'h00, 32'h0000_0005); rd_expect(8'h04, 32'h3412_0001);
        cur_req = "R4";  wr(8'h00, 32'h0000_0001); idle_cyc(1);
        cur_req = "R4";  wr(8'h04, 32'h0);         wr(8'h00, 32'h0000_0001);
        rd_expect(8'h04, 32'h3412_0001);
        cur_req = "R5";  rd_expect(8'h00, 32'h0001_0002);
        cur_req = "R5";  wr(8'h00, 32'h0000_0001); rd_expect(8'h00, 32'h0000_0003);
        cur_req = "R13"; idle_cyc(4);
        chk("hold", 64'(bus_rdata), 64'h0000_0003);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule